// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block runs an automatic erase over any chosen set of flash blocks. The blocks are spread over a low space, a mid space and a high space, and there is also one separate shadow block. Software uses a small register port. It turns on erase mode, marks the blocks it wants in two select registers, and writes the start command. The sequencer drops every selected block whose software lock bit is set. It then erases the remaining blocks one at a time, from the lowest block number to the highest, and reports done and pass.

Each block is a small register array that stands in for flash cells. An erase takes a fixed number of cycles and leaves every bit of the block at 1. Programming can only clear bits (new word = old word AND data). Programming is refused for a locked block and refused while an erase is running.

The low blocks get numbers 0 to N_LOW-1, the mid blocks come next, then the high blocks. The shadow block has number N_BLK, where N_BLK = N_LOW+N_MID+N_HIGH. With the defaults (2 low, 2 mid, 4 high) the blocks are 0..7 and the shadow block is 8.

Top module: `blk_erase_seq`

## Requirements
- R1: After reset, every register reads 0, the status bits read 0, and every word of every block reads all-ones.
- R2: An erase writes all-ones to every word of each block it erases. Blocks it does not erase keep their contents.
- R3: Any subset of blocks 0..N_BLK-1 can be chosen in one operation. Bits [N_LOW+N_MID-1:0] of address 3 select the low and mid blocks, and bits [N_HIGH-1:0] of address 4 select high blocks N_LOW+N_MID and up. Every selected, unlocked block is erased.
- R4: Blocks are erased in ascending number order. Each one takes ERASE_CYCLES cycles. While busy, CTRL bits [19:16] show the block now being erased. Busy lasts exactly (count of erased blocks) × ERASE_CYCLES cycles.
- R5: A selected block whose lock bit is set is not erased. Pass (CTRL bit 10) reads 0 when any selected block was locked and 1 otherwise.
- R6: Both lock registers read back what was written: address 1 holds the low and mid locks in bits [N_LOW+N_MID-1:0] and the shadow lock in bit 31, and address 2 holds the high locks in bits [N_HIGH-1:0]. A program request to a locked block has no effect.
- R7: A write to a select register is ignored unless erase mode (CTRL bit 0) is already 1. The start command is CTRL bit 1, and it only takes effect when the same write also sets bit 0.
- R8: When shadow mode (CTRL bit 2) is set, only the shadow block is the target and the select registers are ignored. The shadow lock still applies.
- R9: If no unlocked block is targeted, done (CTRL bit 9) is 1 in the cycle after the start, busy (CTRL bit 8) never rises, and no block changes.
- R10: While busy, writes to the lock, select and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address (0 ctrl, 1 low/mid lock, 2 high lock, 3 low/mid select, 4 high select) |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| prog_en | input | 1 | Program request |
| prog_blk | input | IW | Block to program |
| prog_word | input | WA | Word within the block |
| prog_data | input | DW | Program data, ANDed into the word |
| arr_blk | input | IW | Array read block |
| arr_word | input | WA | Array read word |
| arr_rdata | output | DW | Array read data (combinational) |

## Verification
The hardest case to reach from the ports is the step order when the selection and the lock pattern overlap in scattered ways. Only the status field shows which block is in progress. The bench steps through all 256 select bitmaps, each with a lock bitmap derived from it. Before each run it programs every block to zero, so any erase it did not expect shows up as all-ones. During busy it records the sequence of block numbers and compares it with the ascending list of selected, unlocked bits. Shadow mode with a full select bitmap, and writes made during busy, are driven separately.

// File: rtl/bes_pkg.sv
// bes_pkg: register addresses, bit positions and the sequencer state type
// shared by the erase sequencer modules. Assumes a 3-bit register address.
package bes_pkg;
    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_LOCK_LM = 3'd1;
    localparam logic [2:0] A_LOCK_HI = 3'd2;
    localparam logic [2:0] A_SEL_LM  = 3'd3;
    localparam logic [2:0] A_SEL_HI  = 3'd4;

    localparam int B_MODE   = 0;
    localparam int B_GO     = 1;
    localparam int B_SHADOW = 2;
    localparam int B_BUSY   = 8;
    localparam int B_DONE   = 9;
    localparam int B_PASS   = 10;
    localparam int B_IDX    = 16;
    localparam int B_SHLOCK = 31;

    typedef enum logic {SQ_IDLE, SQ_ERASE} sq_t;
endpackage

// File: rtl/bes_regs.sv
// bes_regs: software-visible control, lock and select registers.
// Assumes N_LM <= 31 and N_HI <= 32. All writes are refused while busy.
// Select writes also need erase mode to be set beforehand.
module bes_regs
    import bes_pkg::*;
#(
    parameter int N_LM = 4,
    parameter int N_HI = 4,
    localparam int NBLK = N_LM + N_HI
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic            busy,
    output logic            mode,
    output logic            shadow,
    output logic            go,
    output logic [NBLK:0]   lock_vec,
    output logic [NBLK-1:0] sel_vec
);
    logic [N_LM-1:0] lock_lm_q, sel_lm_q;
    logic [N_HI-1:0] lock_hi_q, sel_hi_q;
    logic            sh_lock_q;
    logic            wr_ok;
    logic            unused_wdata;

    // Writes only land while the sequencer is idle.
    assign wr_ok        = wr_en && !busy;
    assign unused_wdata = ^wr_data;

    // Register update for control, lock and select words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= 1'b0;
            shadow    <= 1'b0;
            lock_lm_q <= '0;
            lock_hi_q <= '0;
            sh_lock_q <= 1'b0;
            sel_lm_q  <= '0;
            sel_hi_q  <= '0;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CTRL: begin
                    mode   <= wr_data[B_MODE];
                    shadow <= wr_data[B_SHADOW];
                end
                A_LOCK_LM: begin
                    lock_lm_q <= wr_data[N_LM-1:0];
                    sh_lock_q <= wr_data[B_SHLOCK];
                end
                A_LOCK_HI: lock_hi_q <= wr_data[N_HI-1:0];
                A_SEL_LM:  if (mode) sel_lm_q <= wr_data[N_LM-1:0];
                A_SEL_HI:  if (mode) sel_hi_q <= wr_data[N_HI-1:0];
                default: ;
            endcase
        end
    end

    // Start pulse: control write with the go and mode bits both set.
    assign go       = wr_ok && (wr_addr == A_CTRL) && wr_data[B_GO] && wr_data[B_MODE];
    assign lock_vec = {sh_lock_q, lock_hi_q, lock_lm_q};
    assign sel_vec  = {sel_hi_q, sel_lm_q};
endmodule

// File: rtl/bes_pick.sv
// bes_pick: finds the lowest set bit of a vector. It is combinational.
// Assumes IW is wide enough to hold W-1. idx reads 0 when the vector is empty.
module bes_pick #(
    parameter int W  = 9,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Flag whether anything is pending.
    assign any = |vec;
endmodule

// File: rtl/bes_seq.sv
// bes_seq: erase sequencer. On go it latches the targeted unlocked blocks
// and erases them lowest first, each taking EC cycles. It then raises done.
// Assumes go is only raised while idle, which the register block ensures.
module bes_seq
    import bes_pkg::*;
#(
    parameter int NBT = 9,
    parameter int IW  = 4,
    parameter int EC  = 4,
    localparam int CW = (EC > 1) ? $clog2(EC) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [NBT-1:0] target,
    input  logic [NBT-1:0] lock_vec,
    output logic           busy,
    output logic           done,
    output logic           pass,
    output logic           stb,
    output logic [IW-1:0]  idx
);
    sq_t            st_q;
    logic [NBT-1:0] pend_q, elig, rest;
    logic [CW-1:0]  cnt_q;
    logic           last_cnt;
    logic           any_pend;

    bes_pick #(.W(NBT), .IW(IW)) u_pick (.vec(pend_q), .idx(idx), .any(any_pend));

    // Work out the eligible set, the last-cycle condition and the remaining set.
    assign elig     = target & ~lock_vec;
    assign last_cnt = (cnt_q == CW'(EC - 1));
    assign stb      = (st_q == SQ_ERASE) && last_cnt && any_pend;
    assign rest     = pend_q & ~(NBT'(1) << idx);
    assign busy     = (st_q == SQ_ERASE);

    // State, pending set, cycle counter and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            pend_q <= '0;
            cnt_q  <= '0;
            done   <= 1'b0;
            pass   <= 1'b0;
        end else if (st_q == SQ_IDLE) begin
            if (go) begin
                pend_q <= elig;
                cnt_q  <= '0;
                pass   <= ~|(target & lock_vec);
                done   <= ~|elig;
                st_q   <= (|elig) ? SQ_ERASE : SQ_IDLE;
            end
        end else begin
            if (last_cnt) begin
                pend_q <= rest;
                cnt_q  <= '0;
                if (~|rest) begin
                    st_q <= SQ_IDLE;
                    done <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bes_array.sv
// bes_array: register stand-in for the flash cells. There are NBT blocks of
// WORDS words, each DW bits wide. Reset and erase set a whole block to ones.
// A program ANDs the data into one word. Assumes WORDS is a power of two.
module bes_array #(
    parameter int NBT   = 9,
    parameter int IW    = 4,
    parameter int WORDS = 4,
    parameter int WA    = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_ok,
    input  logic [IW-1:0] prog_blk,
    input  logic [WA-1:0] prog_word,
    input  logic [DW-1:0] prog_data,
    input  logic          ers_stb,
    input  logic [IW-1:0] ers_idx,
    input  logic [IW-1:0] rd_blk,
    input  logic [WA-1:0] rd_word,
    output logic [DW-1:0] rd_data
);
    logic [NBT-1:0][WORDS*DW-1:0] flat;
    logic [WORDS-1:0][DW-1:0]     rd_sel;

    for (genvar b = 0; b < NBT; b++) begin : g_blk
        logic [WORDS-1:0][DW-1:0] cell_q;
        logic                     hit_e, hit_p;

        assign hit_e = ers_stb && (ers_idx == IW'(b));
        assign hit_p = prog_ok && (prog_blk == IW'(b));

        // Cell update for one block: erase wins over program.
        always_ff @(posedge clk) begin
            if (!rst_n)     cell_q <= '1;
            else if (hit_e) cell_q <= '1;
            else if (hit_p) cell_q[prog_word] <= cell_q[prog_word] & prog_data;
        end

        assign flat[b] = cell_q;
    end

    // Read mux. A block number out of range returns zero.
    always_comb begin
        rd_sel  = ({1'b0, rd_blk} < (IW + 1)'(NBT)) ? flat[rd_blk] : '0;
        rd_data = rd_sel[rd_word];
    end
endmodule

// File: rtl/blk_erase_seq.sv
// blk_erase_seq: top of the multi-block erase sequencer. It joins the
// register file, the sequencer and the cell array, and drives the read-back mux.
// Assumes N_LOW+N_MID <= 31, N_HIGH <= 32 and WORDS a power of two.
module blk_erase_seq
    import bes_pkg::*;
#(
    parameter int N_LOW     = 2,
    parameter int N_MID     = 2,
    parameter int N_HIGH    = 4,
    parameter int WORDS     = 4,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 4,
    localparam int N_LM     = N_LOW + N_MID,
    localparam int NBLK     = N_LM + N_HIGH,
    localparam int NBT      = NBLK + 1,
    localparam int IW       = $clog2(NBT),
    localparam int WA       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic [2:0]    reg_raddr,
    output logic [31:0]   reg_rdata,
    input  logic          prog_en,
    input  logic [IW-1:0] prog_blk,
    input  logic [WA-1:0] prog_word,
    input  logic [DW-1:0] prog_data,
    input  logic [IW-1:0] arr_blk,
    input  logic [WA-1:0] arr_word,
    output logic [DW-1:0] arr_rdata
);
    logic            mode_w, shadow_w, go_w;
    logic [NBLK:0]   lock_w;
    logic [NBLK-1:0] sel_w;
    logic [NBT-1:0]  tgt_w;
    logic            busy_w, done_w, pass_w, stb_w;
    logic [IW-1:0]   idx_w;
    logic            prog_ok;

    bes_regs #(.N_LM(N_LM), .N_HI(N_HIGH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .busy(busy_w), .mode(mode_w), .shadow(shadow_w),
        .go(go_w), .lock_vec(lock_w), .sel_vec(sel_w)
    );

    // Shadow mode targets only the shadow block and ignores the select bitmaps.
    assign tgt_w = shadow_w ? {1'b1, {NBLK{1'b0}}} : {1'b0, sel_w};

    bes_seq #(.NBT(NBT), .IW(IW), .EC(ERASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go_w), .target(tgt_w), .lock_vec(lock_w),
        .busy(busy_w), .done(done_w), .pass(pass_w), .stb(stb_w), .idx(idx_w)
    );

    // Program gate: the block must be in range, unlocked, and no erase running.
    assign prog_ok = prog_en && !busy_w &&
                     ({1'b0, prog_blk} < (IW + 1)'(NBT)) && !lock_w[prog_blk];

    bes_array #(.NBT(NBT), .IW(IW), .WORDS(WORDS), .WA(WA), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_ok(prog_ok), .prog_blk(prog_blk),
        .prog_word(prog_word), .prog_data(prog_data), .ers_stb(stb_w),
        .ers_idx(idx_w), .rd_blk(arr_blk), .rd_word(arr_word), .rd_data(arr_rdata)
    );

    // Register read-back mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            A_CTRL: begin
                reg_rdata[B_MODE]      = mode_w;
                reg_rdata[B_SHADOW]    = shadow_w;
                reg_rdata[B_BUSY]      = busy_w;
                reg_rdata[B_DONE]      = done_w;
                reg_rdata[B_PASS]      = pass_w;
                reg_rdata[B_IDX +: IW] = busy_w ? idx_w : '0;
            end
            A_LOCK_LM: begin
                reg_rdata[N_LM-1:0]  = lock_w[N_LM-1:0];
                reg_rdata[B_SHLOCK]  = lock_w[NBLK];
            end
            A_LOCK_HI: reg_rdata[N_HIGH-1:0] = lock_w[NBLK-1:N_LM];
            A_SEL_LM:  reg_rdata[N_LM-1:0]   = sel_w[N_LM-1:0];
            A_SEL_HI:  reg_rdata[N_HIGH-1:0] = sel_w[NBLK-1:N_LM];
            default: ;
        endcase
    end
endmodule

// File: rtl/bes_check.sv
// bes_check: timing properties of the erase sequencer. Bound to blk_erase_seq.
module bes_check #(
    parameter int NBT = 9,
    parameter int IW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           go,
    input logic           stb,
    input logic [IW-1:0]  idx,
    input logic [NBT-1:0] lock_vec,
    input logic [NBT-1:0] target,
    input logic           shadow
);
    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> busy);

    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (idx != $past(idx))) |-> (idx > $past(idx)));

    assert_no_locked_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> !lock_vec[idx]);

    assert_shadow_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && shadow) |-> (idx == IW'(NBT - 1)));

    assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ((target & ~lock_vec) == '0)) |=> (done && !busy));

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ((target & ~lock_vec) != '0)) |=> (busy && !done));

    assert_lock_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lock_vec));
endmodule

bind blk_erase_seq bes_check #(.NBT(NBT), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .go(go_w),
    .stb(stb_w), .idx(idx_w), .lock_vec(lock_w), .target(tgt_w), .shadow(shadow_w)
);

// File: tb/blk_erase_seq_test.sv
`timescale 1ns/1ps
module blk_erase_seq_test;
    localparam int NB    = 8;
    localparam int NBT   = 9;
    localparam int EC    = 4;
    localparam int WORDS = 4;
    localparam logic [2:0] CTRL = 3'd0, LKLM = 3'd1, LKHI = 3'd2, SLLM = 3'd3, SLHI = 3'd4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        prog_en = 1'b0;
    logic [3:0]  prog_blk = '0, arr_blk = '0;
    logic [1:0]  prog_word = '0, arr_word = '0;
    logic [7:0]  prog_data = '0, arr_rdata;

    int errs = 0, checks = 0;
    int busy_cyc, nseq;
    int seq [16];
    logic [31:0] fin;

    blk_erase_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .prog_en(prog_en), .prog_blk(prog_blk), .prog_word(prog_word),
        .prog_data(prog_data), .arr_blk(arr_blk), .arr_word(arr_word),
        .arr_rdata(arr_rdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_raddr = a; #1; v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic prog_all(input int b, input logic [7:0] d);
        for (int w = 0; w < WORDS; w++) begin
            prog_en = 1'b1; prog_blk = 4'(b); prog_word = 2'(w); prog_data = d;
            @(negedge clk);
        end
        prog_en = 1'b0;
    endtask

    // Reads every word of block b; returns the first mismatch with exp, else exp.
    task automatic blk_val(input int b, input logic [7:0] exp, output int got);
        got = int'(exp);
        for (int w = 0; w < WORDS; w++) begin
            arr_blk = 4'(b); arr_word = 2'(w); #1;
            if (arr_rdata != exp && got == int'(exp)) got = int'(arr_rdata);
            @(negedge clk);
        end
    endtask

    // Polls CTRL every cycle until done, recording busy cycles and the block order.
    task automatic watch();
        logic [31:0] v;
        busy_cyc = 0; nseq = 0; fin = '0;
        for (int g = 0; g < 400; g++) begin
            reg_raddr = CTRL; #1; v = reg_rdata;
            if (v[8]) begin
                busy_cyc++;
                if (nseq == 0 || seq[nseq-1] != int'(v[19:16])) begin
                    seq[nseq] = int'(v[19:16]); nseq++;
                end
            end
            if (v[9]) begin fin = v; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(CTRL, v); chk("R1", "ctrl after reset", int'(v), 0);
        rd(LKLM, v); chk("R1", "lock_lm after reset", int'(v), 0);
        rd(SLHI, v); chk("R1", "sel_hi after reset", int'(v), 0);
        blk_val(5, 8'hFF, got); chk("R1", "array after reset", got, 255);

        // R7: select writes and start are ignored without erase mode
        wr(CTRL, 0); wr(SLLM, 32'hF);
        rd(SLLM, v); chk("R7", "sel write without mode", int'(v), 0);
        wr(CTRL, 2);
        rd(CTRL, v); chk("R7", "go without mode busy/done", int'(v[9:8]), 0);
        wr(CTRL, 1); wr(SLLM, 32'h5);
        rd(SLLM, v); chk("R7", "sel write with mode", int'(v), 5);

        // R6: lock read-back, and a program to a locked block has no effect
        wr(LKLM, 32'h8000_000A);
        rd(LKLM, v); chk("R6", "lock_lm readback", int'(v[31:16]), 16'h8000);
        chk("R6", "lock_lm low readback", int'(v[15:0]), 10);
        wr(LKHI, 32'h9);
        rd(LKHI, v); chk("R6", "lock_hi readback", int'(v), 9);
        prog_all(1, 8'h00); blk_val(1, 8'hFF, got); chk("R6", "locked block program", got, 255);
        prog_all(0, 8'h3C); blk_val(0, 8'h3C, got); chk("R6", "unlocked block program", got, 60);

        // R10: writes during busy are ignored
        wr(LKLM, 0); wr(LKHI, 0);
        wr(SLLM, 32'h1); wr(SLHI, 0);
        wr(CTRL, 3);
        wr(LKLM, 32'hF); wr(SLLM, 32'hF); wr(CTRL, 0);
        watch();
        rd(LKLM, v); chk("R10", "lock write during busy", int'(v), 0);
        rd(SLLM, v); chk("R10", "sel write during busy", int'(v), 1);
        rd(CTRL, v); chk("R10", "ctrl write during busy", int'(v[0]), 1);

        // R8: shadow mode ignores the select bitmaps
        prog_all(8, 8'h00); prog_all(0, 8'h00);
        wr(SLLM, 32'hF); wr(SLHI, 32'hF);
        wr(CTRL, 5); wr(CTRL, 7);
        watch();
        chk("R8", "shadow busy cycles", busy_cyc, EC);
        chk("R8", "shadow block order", (nseq == 1) ? seq[0] : -1, 8);
        chk("R8", "shadow pass", int'(fin[10]), 1);
        blk_val(8, 8'hFF, got); chk("R8", "shadow erased", got, 255);
        blk_val(0, 8'h00, got); chk("R8", "selected block untouched", got, 0);
        prog_all(8, 8'h00);
        wr(LKLM, 32'h8000_0000); wr(CTRL, 7);
        watch();
        chk("R9", "locked shadow busy cycles", busy_cyc, 0);
        chk("R9", "locked shadow done", int'(fin[9]), 1);
        chk("R5", "locked shadow pass", int'(fin[10]), 0);
        blk_val(8, 8'h00, got); chk("R5", "locked shadow untouched", got, 0);

        // R2 R3 R4 R5 R9: sweep of every select bitmap with derived locks
        for (int m = 0; m < 256; m++) begin
            int l, elig, k, bad;
            l = (m % 3 == 0) ? 0 : ((m * 37 + 11) & 8'hFF);
            elig = m & ~l & 8'hFF;
            wr(LKLM, 0); wr(LKHI, 0);
            for (int b = 0; b < NBT; b++) prog_all(b, 8'h00);
            wr(CTRL, 1);
            wr(SLLM, 32'(m & 15)); wr(SLHI, 32'(m >> 4));
            wr(LKLM, 32'(l & 15)); wr(LKHI, 32'(l >> 4));
            wr(CTRL, 3);
            watch();
            chk("R9", "done after run", int'(fin[9]), 1);
            chk("R5", "pass flag", int'(fin[10]), ((m & l) == 0) ? 1 : 0);
            chk("R4", "busy cycles", busy_cyc, $countones(elig) * EC);
            k = 0; bad = 0;
            for (int i = 0; i < NB; i++) begin
                if (elig[i]) begin
                    if (k >= nseq || seq[k] != i) bad = 1;
                    k++;
                end
            end
            if (k != nseq) bad = 1;
            chk("R4", "erase order ascending", bad, 0);
            for (int b = 0; b < NBT; b++) begin
                logic [7:0] e;
                e = (b < NB && elig[b]) ? 8'hFF : 8'h00;
                blk_val(b, e, got);
                chk((b < NB && ((m >> b) & 1) == 1) ? "R3" : "R2", "block contents", got, int'(e));
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule